// File: doc/BRIEF.md
# Program Counter with Latched Upper Bytes

This block holds the 21-bit byte address of the next instruction for a small processor whose data bus is eight bits wide. The address is kept as three fields: a low byte, a high byte and a five-bit upper field. Software on the data bus can only read and write the low byte directly. It reaches the two upper fields through two holding latches. Writing the low byte copies both latches into the counter in the same update, so a computed jump over the whole address space takes effect in one step. Reading the low byte refills both latches from the current counter, so software can capture a whole address without tearing.

Hardware control-flow paths do not go through the latches. These are a full-target load for goto, call, relative call and branch, and a load from the return stack. Each writes the whole counter directly and leaves both latches as they were. Between loads, the counter advances by one 16-bit instruction word per fetch. Bit 0 is always held at zero.

Each clock edge applies exactly one update kind, chosen by fixed priority. `UPD_JUMP` loads the hardware target. `UPD_RETURN` loads the return address. `UPD_LOWWR` loads the latches together with the bus byte. `UPD_STEP` adds two. `UPD_HOLD` keeps the value. A cycle moves from any kind to any other kind; the choice depends only on that cycle's requests.

Top module: `pc_latched_unit`

## Requirements
- R1: After reset the counter reads 0x000000, and both holding latches hold zero.
- R2: Bit 0 of the counter is 0 at all times; every load discards bit 0 of its source.
- R3: With `inc_req` high and no load requested, the counter advances by 2 at the clock edge, modulo 2^21 (0x1FFFFE steps to 0x000000).
- R4: With `jmp_valid` high, the counter takes `jmp_target`. With `ret_valid` high and no jump, it takes `ret_addr`. In both cases the latches play no part.
- R5: A bus read at register select 0 (low byte) returns counter bits 7:0 on `bus_rdata` in the same cycle. At the clock edge it copies counter bits 15:8 into the high latch and bits 20:16 into the upper latch.
- R6: A bus write at select 0 sets the counter to {upper latch, high latch, `bus_wdata`} in one update.
- R7: A bus write at select 1 loads the 8-bit high latch, and a write at select 2 loads the upper latch from `bus_wdata` bits 4:0. Neither changes the counter.
- R8: Jump and return loads leave both latches unchanged.
- R9: When several updates are requested in one cycle, the priority is jump, then return, then low-byte write, then step.
- R10: With no update requested, the counter holds its value.
- R11: Select 3 is unused: writes to it change nothing, and `bus_rdata` is 0 except during a read at select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_req | input | 1 | Sequential fetch: advance by one instruction word |
| jmp_valid | input | 1 | Load the hardware target (goto, call, branch) |
| jmp_target | input | 21 | Full target byte address |
| ret_valid | input | 1 | Load the return address from the stack |
| ret_addr | input | 21 | Return byte address |
| bus_wr | input | 1 | Data-bus write strobe |
| bus_rd | input | 1 | Data-bus read strobe |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high latch, 2 upper latch, 3 unused |
| bus_wdata | input | 8 | Data-bus write byte |
| bus_rdata | output | 8 | Data-bus read byte |
| pc_out | output | 21 | Current counter value |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle. When both strobes are set at select 0, it is undefined whether the latch refill or the low-byte load should see the pre-update latches. Every stimulus cycle in the bench raises at most one strobe. Read-data checks are made only in cycles where no update changes the counter, so the sampled low byte is the one the read returned. Combined requests are driven one pair at a time to reach each priority step.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int unsigned PCL_PC_W   = 21;
    localparam int unsigned PCL_BYTE_W = 8;
    localparam int unsigned PCL_STEP   = 2;

    localparam logic [1:0] SEL_LOW  = 2'd0;
    localparam logic [1:0] SEL_HI   = 2'd1;
    localparam logic [1:0] SEL_UP   = 2'd2;

    typedef enum logic [2:0] {
        UPD_HOLD   = 3'd0,
        UPD_STEP   = 3'd1,
        UPD_JUMP   = 3'd2,
        UPD_RETURN = 3'd3,
        UPD_LOWWR  = 3'd4
    } upd_e;

endpackage

// File: rtl/pcl_arbiter.sv
module pcl_arbiter
    import pcl_pkg::*;
(
    input  logic inc_req,
    input  logic jmp_valid,
    input  logic ret_valid,
    input  logic low_wr,
    output upd_e kind
);

    always_comb begin
        if (jmp_valid)      kind = UPD_JUMP;
        else if (ret_valid) kind = UPD_RETURN;
        else if (low_wr)    kind = UPD_LOWWR;
        else if (inc_req)   kind = UPD_STEP;
        else                kind = UPD_HOLD;
    end

endmodule

// File: rtl/pcl_next.sv
module pcl_next
    import pcl_pkg::*;
#(
    parameter int unsigned PC_W       = PCL_PC_W,
    parameter int unsigned BYTE_W     = PCL_BYTE_W,
    parameter int unsigned STEP_BYTES = PCL_STEP,
    localparam int unsigned UP_W      = PC_W - 2 * BYTE_W
) (
    input  upd_e              kind,
    input  logic [PC_W-1:0]   pc_q,
    input  logic [PC_W-1:0]   jmp_target,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] lat_hi,
    input  logic [UP_W-1:0]   lat_up,
    output logic [PC_W-1:0]   pc_d
);

    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);

    logic [PC_W-1:0] raw;

    always_comb begin
        unique case (kind)
            UPD_JUMP:   raw = jmp_target;
            UPD_RETURN: raw = ret_addr;
            UPD_LOWWR:  raw = {lat_up, lat_hi, wdata};
            UPD_STEP:   raw = pc_q + PC_W'(STEP_BYTES);
            UPD_HOLD:   raw = pc_q;
            default:    raw = pc_q;
        endcase
        pc_d = raw & ALIGN_MASK;
    end

endmodule

// File: rtl/pcl_latches.sv
module pcl_latches #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned UP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_up,
    input  logic              refill,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] pc_hi,
    input  logic [UP_W-1:0]   pc_up,
    output logic [BYTE_W-1:0] lat_hi,
    output logic [UP_W-1:0]   lat_up
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_hi <= '0;
        end else if (wr_hi) begin
            lat_hi <= wdata;
        end else if (refill) begin
            lat_hi <= pc_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_up <= '0;
        end else if (wr_up) begin
            lat_up <= wdata[UP_W-1:0];
        end else if (refill) begin
            lat_up <= pc_up;
        end
    end

endmodule

// File: rtl/pc_latched_unit.sv
module pc_latched_unit
    import pcl_pkg::*;
#(
    parameter int unsigned PC_W       = PCL_PC_W,
    parameter int unsigned BYTE_W     = PCL_BYTE_W,
    parameter int unsigned STEP_BYTES = PCL_STEP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_req,
    input  logic              jmp_valid,
    input  logic [PC_W-1:0]   jmp_target,
    input  logic              ret_valid,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [PC_W-1:0]   pc_out
);

    localparam int unsigned UP_W  = PC_W - 2 * BYTE_W;
    localparam int unsigned HI_LO = BYTE_W;
    localparam int unsigned UP_LO = 2 * BYTE_W;

    logic              wr_low, wr_hi, wr_up, rd_low;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [BYTE_W-1:0] lat_hi_q;
    logic [UP_W-1:0]   lat_up_q;
    upd_e              kind;

    // Bus register decode
    always_comb begin
        wr_low = bus_wr && (bus_addr == SEL_LOW);
        wr_hi  = bus_wr && (bus_addr == SEL_HI);
        wr_up  = bus_wr && (bus_addr == SEL_UP);
        rd_low = bus_rd && (bus_addr == SEL_LOW);
    end

    pcl_arbiter u_arb (
        .inc_req   (inc_req),
        .jmp_valid (jmp_valid),
        .ret_valid (ret_valid),
        .low_wr    (wr_low),
        .kind      (kind)
    );

    pcl_next #(
        .PC_W       (PC_W),
        .BYTE_W     (BYTE_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_next (
        .kind       (kind),
        .pc_q       (pc_q),
        .jmp_target (jmp_target),
        .ret_addr   (ret_addr),
        .wdata      (bus_wdata),
        .lat_hi     (lat_hi_q),
        .lat_up     (lat_up_q),
        .pc_d       (pc_d)
    );

    pcl_latches #(
        .BYTE_W (BYTE_W),
        .UP_W   (UP_W)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hi  (wr_hi),
        .wr_up  (wr_up),
        .refill (rd_low),
        .wdata  (bus_wdata),
        .pc_hi  (pc_q[UP_LO-1:HI_LO]),
        .pc_up  (pc_q[PC_W-1:UP_LO]),
        .lat_hi (lat_hi_q),
        .lat_up (lat_up_q)
    );

    // Counter state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // Outputs
    always_comb begin
        pc_out    = pc_q;
        bus_rdata = rd_low ? pc_q[BYTE_W-1:0] : '0;
    end

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
    parameter int unsigned PC_W       = 21,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned STEP_BYTES = 2,
    localparam int unsigned UP_W      = PC_W - 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inc_req,
    input logic              jmp_valid,
    input logic [PC_W-1:0]   jmp_target,
    input logic              ret_valid,
    input logic [PC_W-1:0]   ret_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [PC_W-1:0]   pc_out,
    input logic [BYTE_W-1:0] lat_hi,
    input logic [UP_W-1:0]   lat_up
);

    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);

    logic low_sel;
    assign low_sel = (bus_addr == 2'd0);

    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[0] == 1'b0);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_req && !jmp_valid && !ret_valid && !(bus_wr && low_sel))
        |=> pc_out == $past(pc_out) + PC_W'(STEP_BYTES));

    p_jump_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |=> pc_out == ($past(jmp_target) & ALIGN_MASK));

    p_ret_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !jmp_valid) |=> pc_out == ($past(ret_addr) & ALIGN_MASK));

    p_rdata_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && low_sel) |-> bus_rdata == pc_out[BYTE_W-1:0]);

    p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && low_sel)
        |=> {lat_up, lat_hi} == $past(pc_out[PC_W-1:BYTE_W]));

    p_low_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && low_sel && !jmp_valid && !ret_valid)
        |=> pc_out == ({$past(lat_up), $past(lat_hi), $past(bus_wdata)} & ALIGN_MASK));

    p_latch_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !low_sel && !inc_req && !jmp_valid && !ret_valid)
        |=> $stable(pc_out));

    p_latch_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((jmp_valid || ret_valid) && !bus_wr && !bus_rd)
        |=> ($stable(lat_hi) && $stable(lat_up)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_req && !jmp_valid && !ret_valid && !(bus_wr && low_sel))
        |=> $stable(pc_out));

    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && low_sel) |-> bus_rdata == '0);

endmodule

bind pc_latched_unit pcl_checker #(
    .PC_W       (PC_W),
    .BYTE_W     (BYTE_W),
    .STEP_BYTES (STEP_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_req    (inc_req),
    .jmp_valid  (jmp_valid),
    .jmp_target (jmp_target),
    .ret_valid  (ret_valid),
    .ret_addr   (ret_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pc_out     (pc_out),
    .lat_hi     (lat_hi_q),
    .lat_up     (lat_up_q)
);

// File: tb/sim_pc_latched_unit.sv
`timescale 1ns/1ps
module sim_pc_latched_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_req = 1'b0;
    logic        jmp_valid = 1'b0;
    logic [20:0] jmp_target = '0;
    logic        ret_valid = 1'b0;
    logic [20:0] ret_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [20:0] pc_out;

    always #2.5 clk = ~clk;

    pc_latched_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_req    (inc_req),
        .jmp_valid  (jmp_valid),
        .jmp_target (jmp_target),
        .ret_valid  (ret_valid),
        .ret_addr   (ret_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pc_out     (pc_out)
    );

    typedef struct {
        bit          is_rd;
        logic [20:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;

    // Reference state derived from the requirements
    logic [20:0] m_pc = '0;
    logic [7:0]  m_hi = '0;
    logic [4:0]  m_up = '0;

    task automatic drive(input bit inc, input bit jv, input logic [20:0] jt,
                         input bit rv, input logic [20:0] ra,
                         input bit wr, input bit rd, input logic [1:0] a,
                         input logic [7:0] d, input string tag);
        logic [20:0] old_pc;
        item_t it;
        @(negedge clk);
        inc_req = inc; jmp_valid = jv; jmp_target = jt;
        ret_valid = rv; ret_addr = ra;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        old_pc = m_pc;
        if (jv)                   m_pc = jt & ~21'd1;
        else if (rv)              m_pc = ra & ~21'd1;
        else if (wr && a == 2'd0) m_pc = {m_up, m_hi, d} & ~21'd1;
        else if (inc)             m_pc = m_pc + 21'd2;
        if (wr && a == 2'd1) m_hi = d;
        if (wr && a == 2'd2) m_up = d[4:0];
        if (rd && a == 2'd0) begin
            m_hi = old_pc[15:8];
            m_up = old_pc[20:16];
        end
        it.is_rd = 1'b0; it.exp = m_pc; it.tag = tag;
        sb.push_back(it);
        if (rd) begin
            it.is_rd = 1'b1;
            it.exp = (a == 2'd0) ? {13'd0, old_pc[7:0]} : 21'd0;
            sb.push_back(it);
        end
    endtask

    task automatic idle(input string tag);
        drive(0, 0, '0, 0, '0, 0, 0, 2'd0, 8'd0, tag);
    endtask
    task automatic step(input string tag);
        drive(1, 0, '0, 0, '0, 0, 0, 2'd0, 8'd0, tag);
    endtask
    task automatic jump(input logic [20:0] t, input string tag);
        drive(0, 1, t, 0, '0, 0, 0, 2'd0, 8'd0, tag);
    endtask
    task automatic ret(input logic [20:0] t, input string tag);
        drive(0, 0, '0, 1, t, 0, 0, 2'd0, 8'd0, tag);
    endtask
    task automatic bwr(input logic [1:0] a, input logic [7:0] d, input string tag);
        drive(0, 0, '0, 0, '0, 1, 0, a, d, tag);
    endtask
    task automatic brd(input logic [1:0] a, input string tag);
        drive(0, 0, '0, 0, '0, 0, 1, a, 8'd0, tag);
    endtask

    // Monitor: compare after the update edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (it.is_rd) begin
                    if (bus_rdata !== it.exp[7:0]) begin
                        n_err++;
                        $display("FAIL %s: bus_rdata actual=%02h expected=%02h",
                                 it.tag, bus_rdata, it.exp[7:0]);
                    end
                end else if (pc_out !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: pc_out actual=%06h expected=%06h",
                             it.tag, pc_out, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset value");
        brd(2'd0, "R1 R5 read after reset");
        bwr(2'd0, 8'h41, "R1 R2 R6 latches zero, bit0 dropped");
        step("R3 step 1");
        step("R3 step 2");
        step("R3 step 3");
        bwr(2'd1, 8'h12, "R7 high latch write keeps pc");
        bwr(2'd2, 8'hFF, "R7 upper latch write keeps pc");
        idle("R10 hold");
        bwr(2'd0, 8'h35, "R6 low write transfers latches");
        jump(21'h0ABCD5, "R4 R2 jump target");
        bwr(2'd0, 8'h00, "R8 latches intact after jump");
        ret(21'h054321, "R4 return load");
        bwr(2'd0, 8'h02, "R8 latches intact after return");
        jump(21'h13A5C0, "R4 jump");
        brd(2'd0, "R5 low read and refill");
        jump(21'h000000, "R4 jump zero");
        bwr(2'd0, 8'h10, "R5 refilled latches transfer");
        drive(1, 1, 21'h000100, 0, '0, 0, 0, 2'd0, 8'd0, "R9 jump over step");
        drive(1, 0, '0, 0, '0, 1, 0, 2'd0, 8'h20, "R9 low write over step");
        drive(0, 1, 21'h000200, 1, 21'h000300, 0, 0, 2'd0, 8'd0, "R9 jump over return");
        drive(0, 0, '0, 1, 21'h000400, 1, 0, 2'd0, 8'h50, "R9 return over low write");
        drive(1, 0, '0, 0, '0, 1, 0, 2'd1, 8'h77, "R7 R9 latch write with step");
        jump(21'h1FFFFE, "R4 jump top");
        step("R3 wrap to zero");
        bwr(2'd3, 8'hAB, "R11 unused select write");
        brd(2'd3, "R11 unused select read");
        brd(2'd1, "R11 latch select read");
        bwr(2'd0, 8'h00, "R11 R7 latches after unused write");
        idle("R10 final hold");
        idle("R10 drain");
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule